// File: doc/BRIEF.md
# Universal bus transceiver datapath

This block is an eight-bit, two-way transceiver datapath with one storage element in each direction. The A-to-B element feeds the B port and the B-to-A element feeds the A port. Each element works as a plain buffer, a transparent latch or an edge-triggered register. The mode is picked at run time from a shared latch-enable level and a storage clock owned by that direction. An active-low output enable and a direction select decide which port drives, if any. Tri-state is modelled as an explicit drive-enable output beside each port's data output.

The direction storage clocks are slow control inputs. A fast system clock samples them, and a rising edge is recognised when the current sample is high and the previous one was low. All outputs are registered. Every effect of an input shows on the outputs one system clock edge after the edge that samples it. A synchronous active-high reset empties both storage elements and releases both ports.

Top module: `ubt_datapath`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 one system clock after it is sampled, whatever the other inputs are.
- R2: While `oe_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, one system clock after sampling. `a_oe` and `b_oe` are never 1 together.
- R3: While `le` is 1, `b_out` equals `a_in` and `a_out` equals `b_in`, both not inverted, as sampled on the previous system clock edge.
- R4: While `le` is 0 and a direction's storage clock shows no low-to-high change between samples (held at 0 or at 1), that direction's output keeps its value.
- R5: While `le` is 0, a direction clock sampled 0 and then 1 on the next system edge loads that direction's input, taken on the edge where the 1 is first seen, and the output shows it one system clock later.
- R6: `clk_ab` affects only the A-to-B storage (`b_out`), and `clk_ba` affects only the B-to-A storage (`a_out`).
- R7: When `le` falls, each output holds the last input value it tracked while `le` was 1.
- R8: A direction clock rising edge that arrives while `le` is 1 has no effect beyond the normal tracking of R3.
- R9: A synchronous reset drives `a_out`, `b_out`, `a_oe` and `b_oe` to 0. During reset, both direction clock samples are treated as high, so a clock held at 1 through reset and after it loads nothing.
- R10: The A-to-B storage takes data only from `a_in` and the B-to-A storage only from `b_in`, whichever port is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1: B port driven from A-to-B storage; 0: A port driven from B-to-A storage |
| le | input | 1 | Latch enable shared by both directions; 1 selects transparent tracking |
| clk_ab | input | 1 | Storage clock of the A-to-B direction |
| clk_ba | input | 1 | Storage clock of the B-to-A direction |
| a_in | input | WIDTH | Value seen on the A port |
| b_in | input | WIDTH | Value seen on the B port |
| a_out | output | WIDTH | Value offered to the A port (B-to-A storage) |
| a_oe | output | 1 | Drive enable of the A port |
| b_out | output | WIDTH | Value offered to the B port (A-to-B storage) |
| b_oe | output | 1 | Drive enable of the B port |

## Verification
Every output is due exactly one system clock after the edge that samples the inputs causing it. This holds for a drive enable after `oe_n`/`dir`, for data tracked under `le`, and for data loaded by a direction clock edge. A load depends on two samples of the direction clock, so the change is due one clock after the edge where the clock is first seen high. The bench drives each vector on a falling edge and steps a behavioural model on the next rising edge. It compares all four outputs at the following falling edge, before new inputs are applied, so each result is checked in the one cycle it is due.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_FOLLOW  = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;

  // Follow wins over capture: an edge while tracking adds nothing.
  function automatic store_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return MODE_FOLLOW;
    else if (rise) return MODE_CAPTURE;
    else           return MODE_HOLD;
  endfunction

endpackage

// File: rtl/ubt_edge_detect.sv
module ubt_edge_detect #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RESET_LEVEL;
    else     prev_q <= sclk;
  end

  assign rise = sclk & ~prev_q;

endmodule

// File: rtl/ubt_store.sv
module ubt_store
  import ubt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic             dclk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic        rise;
  store_mode_e mode;

  ubt_edge_detect #(.RESET_LEVEL(1'b1)) i_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (dclk),
    .rise (rise)
  );

  assign mode = pick_mode(le, rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (mode)
        MODE_FOLLOW, MODE_CAPTURE: q <= d;
        default:                   q <= q;
      endcase
    end
  end

  // R3 / R8: tracking while latch enable is high
  a_r3_transparent: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(d)));

  // R4: no edge and no tracking keeps the stored value
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!le && !rise) |=> $stable(q));

  // R5: detected edge with latch enable low loads the input
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (!le && rise) |=> (q == $past(d)));

endmodule

// File: rtl/ubt_port_ctrl.sv
module ubt_port_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else begin
      a_oe <= ~oe_n & ~dir;
      b_oe <= ~oe_n &  dir;
    end
  end

  a_r1_isolation: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!a_oe && !b_oe));

  a_r2_drive_b: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir) |=> (b_oe && !a_oe));

  a_r2_drive_a: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir) |=> (a_oe && !b_oe));

endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             le,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam int NUM_DIR = 2;  // index 0: A-to-B, index 1: B-to-A

  logic [WIDTH-1:0] path_d [NUM_DIR];
  logic [WIDTH-1:0] path_q [NUM_DIR];
  logic             path_clk [NUM_DIR];

  // R10: each path is fed only by its own source port
  assign path_d[0]   = a_in;
  assign path_d[1]   = b_in;
  assign path_clk[0] = clk_ab;
  assign path_clk[1] = clk_ba;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_path
    ubt_store #(.WIDTH(WIDTH)) i_store (
      .clk  (clk),
      .rst  (rst),
      .le   (le),
      .dclk (path_clk[g]),
      .d    (path_d[g]),
      .q    (path_q[g])
    );
  end

  assign b_out = path_q[0];
  assign a_out = path_q[1];

  ubt_port_ctrl i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  // R6: with latch enable low, a path without its own edge stays put
  a_r6_ab_isolated: assert property (@(posedge clk) disable iff (rst)
    (!le && !clk_ab) |=> $stable(b_out));

  a_r6_ba_isolated: assert property (@(posedge clk) disable iff (rst)
    (!le && !clk_ba) |=> $stable(a_out));

endmodule

// File: tb/test_ubt_datapath.sv
module test_ubt_datapath;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         oe_n = 1'b1, dir = 1'b0, le = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural model state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         m_pab = 1'b1, m_pba = 1'b1, m_aoe = 1'b0, m_boe = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  ubt_datapath #(.WIDTH(W)) i_ubt_datapath (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .le(le),
    .clk_ab(clk_ab), .clk_ba(clk_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] next_store(input logic [W-1:0] cur, input logic [W-1:0] din,
                                               input logic lat, input logic sclk, input logic prev);
    if (lat || (sclk && !prev)) return din;
    return cur;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
      summary();
    end
  end

  // drive at a falling edge, step the model at the rising edge, check at the next falling edge
  task automatic apply(input logic r, input logic on, input logic dr, input logic l,
                       input logic cab, input logic cba, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    bit bad;
    rst = r; oe_n = on; dir = dr; le = l; clk_ab = cab; clk_ba = cba; a_in = a; b_in = b;
    @(posedge clk);
    if (r) begin
      m_ab = '0; m_ba = '0; m_pab = 1'b1; m_pba = 1'b1; m_aoe = 1'b0; m_boe = 1'b0;
    end else begin
      m_ab  = next_store(m_ab, a, l, cab, m_pab);
      m_ba  = next_store(m_ba, b, l, cba, m_pba);
      m_pab = cab;
      m_pba = cba;
      m_aoe = !on && !dr;
      m_boe = !on && dr;
    end
    @(negedge clk);
    vectors++;
    bad = (a_out !== m_ba) || (b_out !== m_ab) || (a_oe !== m_aoe) || (b_oe !== m_boe);
    if (bad) begin
      fails++;
      $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b, expected %h %h %b %b",
               tag, a_out, b_out, a_oe, b_oe, m_ba, m_ab, m_aoe, m_boe);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    apply(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R9");
    apply(1, 1, 1, 0, 0, 0, 8'hFF, 8'hFF, "R9");
    // R3 transparent, both directions, no inversion
    apply(0, 0, 1, 1, 0, 0, 8'hA5, 8'h3C, "R3");
    apply(0, 0, 1, 1, 0, 0, 8'h5A, 8'hC3, "R3");
    // R7 latch enable falls: last tracked values held
    apply(0, 0, 1, 0, 0, 0, 8'hFF, 8'h00, "R7");
    // R4 clocks steady low
    apply(0, 0, 1, 0, 0, 0, 8'h12, 8'h34, "R4");
    // R5 rising A-to-B clock loads a_in
    apply(0, 0, 1, 0, 1, 0, 8'hC3, 8'h99, "R5");
    // R4 clock steady high
    apply(0, 0, 1, 0, 1, 0, 8'h11, 8'h22, "R4");
    // R6 only the B-to-A clock rises: b_out unchanged
    apply(0, 0, 1, 0, 1, 1, 8'h66, 8'h77, "R6");
    apply(0, 0, 1, 0, 0, 0, 8'h01, 8'h02, "R6");
    apply(0, 0, 1, 0, 1, 0, 8'hE1, 8'hE2, "R6");
    // R8 edges while latch enable high add nothing beyond tracking
    apply(0, 0, 1, 1, 0, 0, 8'h0F, 8'hF0, "R8");
    apply(0, 0, 1, 1, 1, 1, 8'h33, 8'h44, "R8");
    apply(0, 0, 1, 0, 1, 1, 8'h55, 8'h66, "R8");
    // R1 isolation, any direction
    apply(0, 1, 1, 1, 0, 0, 8'h81, 8'h18, "R1");
    apply(0, 1, 0, 0, 0, 0, 8'h82, 8'h28, "R1");
    // R2 direction select
    apply(0, 0, 0, 1, 0, 0, 8'h9A, 8'hA9, "R2");
    apply(0, 0, 1, 1, 0, 0, 8'h9B, 8'hB9, "R2");
    // R10 B port driving: a_out follows b_in only, b_out follows a_in only
    apply(0, 0, 1, 1, 0, 0, 8'h00, 8'hFE, "R10");
    apply(0, 0, 0, 1, 0, 0, 8'hEF, 8'h00, "R10");
    // R9 clock held high through reset loads nothing afterwards
    apply(1, 0, 1, 0, 1, 1, 8'h77, 8'h77, "R9");
    apply(0, 0, 1, 0, 1, 1, 8'h77, 8'h88, "R9");
    apply(0, 0, 1, 0, 1, 1, 8'h79, 8'h89, "R9");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic r, on, dr, l, cab, cba;
      string tag;
      r   = ($urandom % 100) == 0;
      on  = ($urandom % 5) == 0;
      dr  = $urandom % 2;
      l   = ($urandom % 4) == 0;
      cab = (($urandom % 3) == 0) ? ~clk_ab : clk_ab;
      cba = (($urandom % 3) == 0) ? ~clk_ba : clk_ba;
      if (r)                                      tag = "R9";
      else if (l)                                 tag = "R3";
      else if ((cab && !m_pab) || (cba && !m_pba)) tag = "R5";
      else                                        tag = "R4";
      apply(r, on, dr, l, cab, cba, W'($urandom), W'($urandom), tag);
    end
    summary();
  end

endmodule